// File: doc/BRIEF.md
# Regular-Sequence Conversion Scheduler

This block sequences a multi-channel converter through a programmable list of up to sixteen channel numbers. It issues one conversion at a time to an abstract converter port: a one-cycle start pulse with a channel select, then a one-cycle done pulse that carries the sample. Each finished sample overwrites a single result register, sets a sticky end-of-conversion flag, and is offered on a valid/ready result stream for a DMA-style consumer. A one-cycle end-of-sequence pulse marks the completion of the final list entry.

Three run modes are supported. In single mode one trigger walks the whole list once. In continuous mode the list is repeated without further triggers until the mode is switched off, and the walk then stops at the end of the list. In group mode (discontinuous) each trigger converts only the next n entries, resuming where the previous group stopped. A shortened final group closes the list, and the next trigger starts again at entry 0. Group mode takes precedence over continuous mode.

Back-pressure rule: a result word stays on the stream, unchanged, until it is accepted. No new conversion is started while a word is waiting and `strm_ready_i` is low. The result register and the end-of-conversion flag do not depend on the stream.

Top module: `adc_seq_sched`

## Requirements
- R1: With group mode on, each accepted trigger converts the next n list entries in order, continuing from the entry after the last one converted.
- R2: In group mode, when fewer than n entries remain, the trigger converts only those entries. After the last entry the position returns to entry 0, and the next trigger converts from entry 0.
- R3: With group mode off, an accepted trigger converts every entry from entry 0 through the last one, whatever position an earlier group left.
- R4: The 3-bit group field encodes n as field+1 (0 gives 1, 7 gives 8). The 4-bit length field encodes the list length as field+1 (0 gives one entry, 15 gives sixteen). Entry k occupies bits [5k+4:5k] of the slot list.
- R5: Each conversion is requested with one `conv_start_o` pulse, with `conv_chan_o` equal to the current list entry. The cycle after `conv_done_i` is sampled, `res_data_o` holds that conversion's sample, replacing the previous one.
- R6: `eoc_flag_o` reads 1 from the cycle after every completed conversion. It stays 1 until a cycle with `eoc_clr_i` high and no completing conversion, after which it reads 0.
- R7: `eos_pulse_o` is high for exactly one cycle, the cycle after the conversion of the last list entry completes, and is low at all other times.
- R8: A trigger that arrives while a conversion or group is in progress is ignored: it changes neither the number of conversions nor the list position.
- R9: With continuous mode on and group mode off, one trigger repeats the list endlessly. After continuous mode is switched off, conversions stop at the end of the list.
- R10: The cycle after each completion, `strm_valid_o` is 1 and `strm_data_o` equals {channel[4:0], sample[11:0]}. Valid and data hold while ready is low, and no `conv_start_o` occurs while a word waits without ready.
- R11: After reset, start, valid, the end-of-conversion flag, the end-of-sequence pulse and the result register are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_disc_en | input | 1 | Group (discontinuous) mode enable |
| cfg_cont_en | input | 1 | Continuous mode enable |
| cfg_grp_enc | input | 3 | Group size minus one |
| cfg_len_enc | input | 4 | List length minus one |
| cfg_slot_list | input | 80 | Sixteen 5-bit channel numbers, entry 0 in the low bits |
| trig_i | input | 1 | Trigger, sampled while idle |
| conv_start_o | output | 1 | One-cycle conversion request |
| conv_chan_o | output | 5 | Channel to convert |
| conv_done_i | input | 1 | One-cycle completion from converter |
| conv_data_i | input | 12 | Sample, valid with conv_done_i |
| res_data_o | output | 12 | Latest sample |
| eoc_flag_o | output | 1 | Sticky end-of-conversion flag |
| eoc_clr_i | input | 1 | Write-one-to-clear for the flag |
| eos_pulse_o | output | 1 | End-of-sequence pulse |
| strm_valid_o | output | 1 | Result stream valid |
| strm_ready_i | input | 1 | Result stream ready |
| strm_data_o | output | 17 | {channel, sample} |

## Verification
A sampled trigger raises `conv_start_o` in the next cycle. A sampled done is followed in the next cycle by the new result register, flag, stream word and end-of-sequence pulse. The bench drives control inputs just after the rising edge and samples every output at the falling edge. A behavioural model, built from a position counter and a slot array, predicts the channel of each start and the contents that must appear one cycle after each done. The end-of-sequence output is compared in every cycle. Conversion counts per trigger are checked once the block has been idle long enough for any pending work to appear.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } sched_st_e;
endpackage

// File: rtl/seq_slot_mux.sv
module seq_slot_mux #(
  parameter int NUM_SLOTS = 16,
  parameter int CH_W      = 5,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS*CH_W-1:0] list_i,
  input  logic [IDX_W-1:0]          idx_i,
  output logic [CH_W-1:0]           chan_o
);
  logic [CH_W-1:0] slot_arr [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_unpack
    assign slot_arr[g] = list_i[g*CH_W +: CH_W];
  end

  assign chan_o = slot_arr[idx_i];
endmodule

// File: rtl/seq_position.sv
module seq_position #(
  parameter int IDX_W = 4,
  parameter int GRP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pos_clr_i,
  input  logic             grp_clr_i,
  input  logic             advance_i,
  input  logic [IDX_W-1:0] len_enc_i,
  input  logic [GRP_W-1:0] grp_enc_i,
  output logic [IDX_W-1:0] pos_o,
  output logic             last_o,
  output logic             grp_last_o
);
  logic [IDX_W-1:0] pos_q;
  logic [GRP_W-1:0] grp_q;

  assign last_o     = (pos_q >= len_enc_i);
  assign grp_last_o = (grp_q == grp_enc_i);
  assign pos_o      = pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      grp_q <= '0;
    end else begin
      if (pos_clr_i)      pos_q <= '0;
      else if (advance_i) pos_q <= last_o ? '0 : pos_q + 1'b1;
      if (grp_clr_i)      grp_q <= '0;
      else if (advance_i) grp_q <= grp_q + 1'b1;
    end
  end

  // R1: a non-final conversion moves to the following entry
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !last_o && !pos_clr_i) |=> (pos_q == $past(pos_q) + 1'b1));
  // R2: completing the final entry returns to entry 0
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && last_o) |=> (pos_q == '0));
  // R1: a new group starts counting from zero
  p_grp_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    grp_clr_i |=> (grp_q == '0));
endmodule

// File: rtl/seq_result.sv
module seq_result #(
  parameter int CH_W   = 5,
  parameter int DATA_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   done_i,
  input  logic                   last_i,
  input  logic [CH_W-1:0]        chan_i,
  input  logic [DATA_W-1:0]      data_i,
  input  logic                   eoc_clr_i,
  input  logic                   strm_ready_i,
  output logic [DATA_W-1:0]      res_data_o,
  output logic                   eoc_flag_o,
  output logic                   eos_pulse_o,
  output logic                   strm_valid_o,
  output logic [CH_W+DATA_W-1:0] strm_data_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_data_o   <= '0;
      eoc_flag_o   <= 1'b0;
      eos_pulse_o  <= 1'b0;
      strm_valid_o <= 1'b0;
      strm_data_o  <= '0;
    end else begin
      eos_pulse_o <= done_i && last_i;
      if (done_i) res_data_o <= data_i;
      if (done_i)         eoc_flag_o <= 1'b1;
      else if (eoc_clr_i) eoc_flag_o <= 1'b0;
      if (done_i) begin
        strm_valid_o <= 1'b1;
        strm_data_o  <= {chan_i, data_i};
      end else if (strm_ready_i) begin
        strm_valid_o <= 1'b0;
      end
    end
  end

  // R10: a waiting word is held unchanged
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strm_valid_o && !strm_ready_i && !done_i) |=> (strm_valid_o && $stable(strm_data_o)));
  // R6: flag is sticky without a clear
  p_eoc_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_flag_o && !eoc_clr_i) |=> eoc_flag_o);
  // R6: every completion sets the flag, even against a clear
  p_eoc_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> eoc_flag_o);
endmodule

// File: rtl/adc_seq_sched.sv
module adc_seq_sched
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int CH_W      = 5,
  parameter int DATA_W    = 12,
  parameter int GRP_W     = 3,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_disc_en,
  input  logic                      cfg_cont_en,
  input  logic [GRP_W-1:0]          cfg_grp_enc,
  input  logic [IDX_W-1:0]          cfg_len_enc,
  input  logic [NUM_SLOTS*CH_W-1:0] cfg_slot_list,
  input  logic                      trig_i,
  output logic                      conv_start_o,
  output logic [CH_W-1:0]           conv_chan_o,
  input  logic                      conv_done_i,
  input  logic [DATA_W-1:0]         conv_data_i,
  output logic [DATA_W-1:0]         res_data_o,
  output logic                      eoc_flag_o,
  input  logic                      eoc_clr_i,
  output logic                      eos_pulse_o,
  output logic                      strm_valid_o,
  input  logic                      strm_ready_i,
  output logic [CH_W+DATA_W-1:0]    strm_data_o
);
  sched_st_e        st_q, st_d;
  logic [IDX_W-1:0] pos;
  logic             last_entry, grp_last;
  logic             can_issue, accept_trig, done_ok, grp_end, rerun;

  assign can_issue    = !strm_valid_o || strm_ready_i;
  assign accept_trig  = (st_q == ST_IDLE) && trig_i;
  assign conv_start_o = (st_q == ST_ISSUE) && can_issue;
  assign done_ok      = (st_q == ST_WAIT) && conv_done_i;
  assign grp_end      = last_entry || (cfg_disc_en && grp_last);
  assign rerun        = last_entry && !cfg_disc_en && cfg_cont_en;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (trig_i) st_d = ST_ISSUE;
      ST_ISSUE: if (can_issue) st_d = ST_WAIT;
      ST_WAIT:  if (conv_done_i) st_d = (!grp_end || rerun) ? ST_ISSUE : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  seq_position #(.IDX_W(IDX_W), .GRP_W(GRP_W)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .pos_clr_i (accept_trig && !cfg_disc_en),
    .grp_clr_i (accept_trig),
    .advance_i (done_ok),
    .len_enc_i (cfg_len_enc),
    .grp_enc_i (cfg_grp_enc),
    .pos_o     (pos),
    .last_o    (last_entry),
    .grp_last_o(grp_last)
  );

  seq_slot_mux #(.NUM_SLOTS(NUM_SLOTS), .CH_W(CH_W)) u_mux (
    .list_i(cfg_slot_list),
    .idx_i (pos),
    .chan_o(conv_chan_o)
  );

  seq_result #(.CH_W(CH_W), .DATA_W(DATA_W)) u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_i      (done_ok),
    .last_i      (last_entry),
    .chan_i      (conv_chan_o),
    .data_i      (conv_data_i),
    .eoc_clr_i   (eoc_clr_i),
    .strm_ready_i(strm_ready_i),
    .res_data_o  (res_data_o),
    .eoc_flag_o  (eoc_flag_o),
    .eos_pulse_o (eos_pulse_o),
    .strm_valid_o(strm_valid_o),
    .strm_data_o (strm_data_o)
  );

  // R10: no request while a result word is stalled
  p_issue_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strm_valid_o && !strm_ready_i) |-> !conv_start_o);
  // R5: each request is a single-cycle pulse
  p_start_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);
  // R7: end-of-sequence never lasts two cycles
  p_eos_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eos_pulse_o |=> !eos_pulse_o);
  // R8: a trigger during a conversion leaves the position alone
  p_busy_trig_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_WAIT) && trig_i && !conv_done_i) |=> $stable(pos));
endmodule

// File: tb/test_adc_seq_sched.sv
`timescale 1ns/1ps
module test_adc_seq_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_disc_en = 1'b0, cfg_cont_en = 1'b0;
  logic [2:0]  cfg_grp_enc = '0;
  logic [3:0]  cfg_len_enc = '0;
  logic [79:0] slot_flat;
  logic        trig = 1'b0, conv_done = 1'b0, eoc_clr = 1'b0, ready = 1'b1;
  logic [11:0] conv_data = '0;
  logic        conv_start_o, eoc_flag_o, eos_pulse_o, strm_valid_o;
  logic [4:0]  conv_chan_o;
  logic [11:0] res_data_o;
  logic [16:0] strm_data_o;
  logic [4:0]  slot [16];

  int n_chk = 0, n_fail = 0;
  int mpos = 0, conv_cnt = 0, eos_cnt = 0, cd = 0, lat = 2;
  logic [4:0]  pend_chan = '0;
  logic [11:0] pend_data = '0;
  bit pend_last = 0, done_prev = 0;

  always #2.5 clk = ~clk;

  always_comb for (int i = 0; i < 16; i++) slot_flat[i*5 +: 5] = slot[i];

  adc_seq_sched i_adc_seq_sched (
    .clk(clk), .rst_n(rst_n), .cfg_disc_en(cfg_disc_en), .cfg_cont_en(cfg_cont_en),
    .cfg_grp_enc(cfg_grp_enc), .cfg_len_enc(cfg_len_enc), .cfg_slot_list(slot_flat),
    .trig_i(trig), .conv_start_o(conv_start_o), .conv_chan_o(conv_chan_o),
    .conv_done_i(conv_done), .conv_data_i(conv_data), .res_data_o(res_data_o),
    .eoc_flag_o(eoc_flag_o), .eoc_clr_i(eoc_clr), .eos_pulse_o(eos_pulse_o),
    .strm_valid_o(strm_valid_o), .strm_ready_i(ready), .strm_data_o(strm_data_o));

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model and converter, evaluated at every falling edge
  always @(negedge clk) if (rst_n) begin
    if (done_prev) begin
      chk("R5", "result register", int'(res_data_o), int'(pend_data));
      chk("R6", "eoc flag", int'(eoc_flag_o), 1);
      chk("R7", "eos pulse", int'(eos_pulse_o), int'(pend_last));
      chk("R10", "stream valid", int'(strm_valid_o), 1);
      chk("R10", "stream word", int'(strm_data_o), int'({pend_chan, pend_data}));
      if (eos_pulse_o) eos_cnt++;
    end else begin
      chk("R7", "eos idle", int'(eos_pulse_o), 0);
    end
    done_prev = 0;
    conv_done = 1'b0;
    if (cd > 0) begin
      cd--;
      if (cd == 0) begin
        pend_data = 12'((int'(pend_chan) * 53 + conv_cnt * 29 + 5) % 4096);
        conv_data = pend_data;
        conv_done = 1'b1;
        done_prev = 1;
      end
    end
    if (conv_start_o) begin
      chk("R5", "start channel", int'(conv_chan_o), int'(slot[mpos]));
      pend_chan = slot[mpos];
      pend_last = (mpos == int'(cfg_len_enc));
      mpos = pend_last ? 0 : mpos + 1;
      conv_cnt++;
      cd = lat;
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic fire(bit restart);
    tick();
    trig = 1'b1;
    if (restart) mpos = 0;
    tick();
    trig = 1'b0;
  endtask

  task automatic quiet();
    repeat (160) tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base, eb;
    for (int i = 0; i < 16; i++) slot[i] = 5'((i * 7 + 11) % 32);
    slot[0] = 5'd0; slot[1] = 5'd1; slot[2] = 5'd2; slot[3] = 5'd3;
    slot[4] = 5'd6; slot[5] = 5'd7; slot[6] = 5'd9; slot[7] = 5'd10;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R11 reset state
    chk("R11", "start", int'(conv_start_o), 0);
    chk("R11", "valid", int'(strm_valid_o), 0);
    chk("R11", "eoc", int'(eoc_flag_o), 0);
    chk("R11", "eos", int'(eos_pulse_o), 0);
    chk("R11", "result", int'(res_data_o), 0);

    // R1/R2: groups of three over eight entries
    cfg_disc_en = 1'b1; cfg_grp_enc = 3'd2; cfg_len_enc = 4'd7;
    base = conv_cnt; fire(0); quiet();
    chk("R1", "group 1 count", conv_cnt - base, 3);
    base = conv_cnt; fire(0); quiet();
    chk("R1", "group 2 count", conv_cnt - base, 3);
    base = conv_cnt; eb = eos_cnt; fire(0); quiet();
    chk("R2", "short group count", conv_cnt - base, 2);
    chk("R2", "eos after short group", eos_cnt - eb, 1);
    chk("R2", "model wrapped", mpos, 0);
    base = conv_cnt; fire(0); quiet();
    chk("R2", "group after wrap", conv_cnt - base, 3);

    // R8: second trigger during a group
    lat = 4;
    base = conv_cnt; fire(0);
    repeat (3) tick();
    trig = 1'b1; tick(); trig = 1'b0;
    quiet();
    chk("R8", "busy trigger count", conv_cnt - base, 3);
    chk("R8", "position after group", mpos, 6);

    // R3: whole list from entry 0
    lat = 2; cfg_disc_en = 1'b0;
    base = conv_cnt; eb = eos_cnt; fire(1); quiet();
    chk("R3", "full list count", conv_cnt - base, 8);
    chk("R3", "eos count", eos_cnt - eb, 1);

    // R4: field zero gives one entry / group of one
    cfg_disc_en = 1'b1; cfg_grp_enc = 3'd0; cfg_len_enc = 4'd0;
    base = conv_cnt; eb = eos_cnt; fire(0); quiet();
    chk("R4", "one entry count", conv_cnt - base, 1);
    chk("R4", "one entry eos", eos_cnt - eb, 1);
    base = conv_cnt; fire(0); quiet();
    chk("R4", "one entry repeat", conv_cnt - base, 1);

    // R4: group of eight over sixteen entries, latency 1
    lat = 1; cfg_grp_enc = 3'd7; cfg_len_enc = 4'd15;
    base = conv_cnt; eb = eos_cnt; fire(0); quiet();
    chk("R4", "group of eight", conv_cnt - base, 8);
    chk("R4", "no eos mid list", eos_cnt - eb, 0);
    base = conv_cnt; fire(0); quiet();
    chk("R4", "second eight", conv_cnt - base, 8);
    chk("R4", "eos at sixteen", eos_cnt - eb, 1);

    // R6: write-one-to-clear
    chk("R6", "flag before clear", int'(eoc_flag_o), 1);
    tick(); eoc_clr = 1'b1; tick(); eoc_clr = 1'b0;
    chk("R6", "flag after clear", int'(eoc_flag_o), 0);

    // R9: continuous repeat, then stop at end of list
    lat = 2; cfg_disc_en = 1'b0; cfg_cont_en = 1'b1; cfg_len_enc = 4'd3;
    base = conv_cnt; eb = eos_cnt; fire(1);
    repeat (60) tick();
    cfg_cont_en = 1'b0;
    quiet();
    chk("R9", "ends on list boundary", (conv_cnt - base) % 4, 0);
    chk("R9", "repeated", int'((conv_cnt - base) >= 8), 1);
    chk("R9", "eos per pass", eos_cnt - eb, (conv_cnt - base) / 4);

    // R10: back-pressure stalls the next request
    ready = 1'b0;
    base = conv_cnt; fire(1);
    repeat (40) tick();
    chk("R10", "stalled count", conv_cnt - base, 1);
    chk("R10", "word held", int'(strm_valid_o), 1);
    ready = 1'b1;
    quiet();
    chk("R10", "resumed count", conv_cnt - base, 4);
    chk("R10", "stream drained", int'(strm_valid_o), 0);

    finish_run();
  end
endmodule